// File: doc/BRIEF.md
# Split Data/Code Tracking Buffer

This block sits on the receive side of a shared, snooped bus. On that bus, every protected transfer is sent as two separate transactions. The data block goes first. Its authentication code follows in a later transaction. Code transactions for older transfers may fall between newer data transactions. For example, the data for id+1 can arrive before the code for id. The block lets the receiver use the data speculatively while its code is still outstanding.

When a data transaction is accepted, the block allocates a free slot. The slot records the transaction ID and the bus sequence number of that transaction. The slot index is returned as a tag. Downstream logic holds this tag and uses the query port to ask whether the data behind it has been authenticated.

A code transaction carries two values:
- the code computed locally from the decrypted data;
- the code received from the bus.

The block looks up the pending slot with that ID. If the two codes agree, the slot is marked verified. If they disagree, or if no pending slot holds that ID, a fault is raised. A slot is freed only when it is verified and its tag is released.

Top module: `split_mac_tracker`

## Requirements
- R1: After reset all slots are free: `dat_ready` is 1, `dat_tag` is 0, both fault outputs are 0, and a query of any tag returns `qry_valid`=0 and `qry_verified`=0.
- R2: When `dat_valid` and `dat_ready` are both high at a clock edge, the slot named by `dat_tag` is allocated. `dat_tag` always names the lowest-numbered free slot. From the next cycle, a query of that tag returns `qry_valid`=1, `qry_verified`=0, and the accepted ID and sequence number.
- R3: When every slot is allocated, `dat_ready` is 0. A `dat_valid` presented while full is ignored and alters no slot.
- R4: A code transaction whose expected and received codes are equal marks the matching pending slot verified from the next cycle. Other slots are unaffected. Code transactions may arrive in any order relative to data transactions.
- R5: A code transaction whose codes differ, and that finds a pending slot with its ID, pulses `fault_mismatch` for exactly one cycle, in the cycle after the transaction. The slot stays unverified.
- R6: A code transaction that finds no pending slot with its ID pulses `fault_orphan` for one cycle, in the cycle after the transaction. This also applies when the only slot with that ID is already verified. No slot changes.
- R7: `fault_mismatch` and `fault_orphan` are never high together.
- R8: When several pending slots hold the same ID, a code transaction is matched against the lowest-numbered of them.
- R9: `rel_valid` with `rel_tag` frees that slot from the next cycle, but only if the slot is verified. A release of an unverified slot is ignored.
- R10: A slot is never reported verified while it is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dat_valid | input | 1 | A data transaction is presented |
| dat_id | input | ID_W | Transaction ID of the data |
| dat_seq | input | SEQ_W | Bus sequence number of the data |
| dat_ready | output | 1 | A free slot exists (backpressure when 0) |
| dat_tag | output | IDX_W | Slot that the presented data will occupy |
| mac_valid | input | 1 | A code transaction is presented |
| mac_id | input | ID_W | Transaction ID the code belongs to |
| mac_expect | input | MAC_W | Code computed locally over the data |
| mac_recv | input | MAC_W | Code received from the bus |
| qry_tag | input | IDX_W | Slot being queried |
| qry_valid | output | 1 | Queried slot is allocated |
| qry_verified | output | 1 | Queried slot has passed authentication |
| qry_id | output | ID_W | ID held by the queried slot |
| qry_seq | output | SEQ_W | Sequence number held by the queried slot |
| rel_valid | input | 1 | Release request |
| rel_tag | input | IDX_W | Slot to release |
| fault_mismatch | output | 1 | One-cycle pulse: codes disagreed |
| fault_orphan | output | 1 | One-cycle pulse: code with no pending data |

## Verification
Each kind of corrupted slot state shows up at the ports within one cycle:
- A stale valid or verified bit shows as a wrong `dat_tag` or a wrong query result, in the same cycle as the corruption.
- A misrouted code update marks the wrong tag verified on the next edge. It can also turn a correct code into a false `fault_orphan`.
- A lost free bit shows up as early backpressure.

The directed scenarios therefore query every affected tag, and also a neighbouring tag, right after each edge that should change them.

// File: rtl/split_mac_tracker_pkg.sv
package split_mac_tracker_pkg;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_MISMATCH = 2'd1,
        FLT_ORPHAN   = 2'd2
    } fault_e;

endpackage

// File: rtl/lowest_one.sv
module lowest_one #(
    parameter int N    = 8,
    localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tag_matcher.sv
module tag_matcher #(
    parameter int DEPTH = 8,
    parameter int ID_W  = 8
) (
    input  logic [DEPTH-1:0]           valid,
    input  logic [DEPTH-1:0]           verified,
    input  logic [DEPTH-1:0][ID_W-1:0] ids,
    input  logic [ID_W-1:0]            key,
    output logic [DEPTH-1:0]           hit
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = valid[g] & ~verified[g] & (ids[g] == key);
    end
endmodule

// File: rtl/split_mac_tracker.sv
module split_mac_tracker
    import split_mac_tracker_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ID_W  = 8,
    parameter int SEQ_W = 16,
    parameter int MAC_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dat_valid,
    input  logic [ID_W-1:0]  dat_id,
    input  logic [SEQ_W-1:0] dat_seq,
    output logic             dat_ready,
    output logic [IDX_W-1:0] dat_tag,
    input  logic             mac_valid,
    input  logic [ID_W-1:0]  mac_id,
    input  logic [MAC_W-1:0] mac_expect,
    input  logic [MAC_W-1:0] mac_recv,
    input  logic [IDX_W-1:0] qry_tag,
    output logic             qry_valid,
    output logic             qry_verified,
    output logic [ID_W-1:0]  qry_id,
    output logic [SEQ_W-1:0] qry_seq,
    input  logic             rel_valid,
    input  logic [IDX_W-1:0] rel_tag,
    output logic             fault_mismatch,
    output logic             fault_orphan
);

    typedef struct packed {
        logic [DEPTH-1:0]            valid;
        logic [DEPTH-1:0]            verified;
        logic [DEPTH-1:0][ID_W-1:0]  id;
        logic [DEPTH-1:0][SEQ_W-1:0] seq;
        fault_e                      fault;
    } state_t;

    state_t state_d, state_q;

    logic [DEPTH-1:0] free_vec;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [DEPTH-1:0] hit_vec;
    logic             hit_found;
    logic [IDX_W-1:0] hit_idx;
    logic [DEPTH-1:0] valid_vec;
    logic [DEPTH-1:0] verified_vec;

    assign free_vec     = ~state_q.valid;
    assign valid_vec    = state_q.valid;
    assign verified_vec = state_q.verified;

    lowest_one #(.N(DEPTH)) u_free_pick (
        .req   (free_vec),
        .found (free_found),
        .idx   (free_idx)
    );

    tag_matcher #(.DEPTH(DEPTH), .ID_W(ID_W)) u_match (
        .valid    (state_q.valid),
        .verified (state_q.verified),
        .ids      (state_q.id),
        .key      (mac_id),
        .hit      (hit_vec)
    );

    lowest_one #(.N(DEPTH)) u_hit_pick (
        .req   (hit_vec),
        .found (hit_found),
        .idx   (hit_idx)
    );

    always_comb begin
        state_d       = state_q;
        state_d.fault = FLT_NONE;

        // release: only verified slots may be freed
        if (rel_valid && state_q.valid[rel_tag] && state_q.verified[rel_tag]) begin
            state_d.valid[rel_tag]    = 1'b0;
            state_d.verified[rel_tag] = 1'b0;
        end

        // code arrival, matched against pending slots of the current state
        if (mac_valid) begin
            if (!hit_found) begin
                state_d.fault = FLT_ORPHAN;
            end else if (mac_expect == mac_recv) begin
                state_d.verified[hit_idx] = 1'b1;
            end else begin
                state_d.fault = FLT_MISMATCH;
            end
        end

        // data arrival takes a slot that is free in the current state
        if (dat_valid && free_found) begin
            state_d.valid[free_idx]    = 1'b1;
            state_d.verified[free_idx] = 1'b0;
            state_d.id[free_idx]       = dat_id;
            state_d.seq[free_idx]      = dat_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dat_ready      = free_found;
    assign dat_tag        = free_idx;
    assign qry_valid      = state_q.valid[qry_tag];
    assign qry_verified   = state_q.verified[qry_tag];
    assign qry_id         = state_q.id[qry_tag];
    assign qry_seq        = state_q.seq[qry_tag];
    assign fault_mismatch = (state_q.fault == FLT_MISMATCH);
    assign fault_orphan   = (state_q.fault == FLT_ORPHAN);

endmodule

// File: rtl/split_mac_tracker_chk.sv
module split_mac_tracker_chk #(
    parameter int DEPTH = 8,
    parameter int MAC_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dat_ready,
    input logic [DEPTH-1:0] valid_vec,
    input logic [DEPTH-1:0] verified_vec,
    input logic             mac_valid,
    input logic [MAC_W-1:0] mac_expect,
    input logic [MAC_W-1:0] mac_recv,
    input logic             hit_found,
    input logic [IDX_W-1:0] hit_idx,
    input logic             rel_valid,
    input logic [IDX_W-1:0] rel_tag,
    input logic             fault_mismatch,
    input logic             fault_orphan
);
    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_ready |-> ($countones(valid_vec) == DEPTH));

    assert_good_code_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_valid && hit_found && (mac_expect == mac_recv)) |=> verified_vec[$past(hit_idx)]);

    assert_bad_code_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_valid && hit_found && (mac_expect != mac_recv)) |=> fault_mismatch);

    assert_orphan_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_valid && !hit_found) |=> fault_orphan);

    assert_single_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_mismatch, fault_orphan}));

    assert_hold_unverified_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && valid_vec[rel_tag] && !verified_vec[rel_tag]) |=> valid_vec[$past(rel_tag)]);

    assert_verified_allocated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (verified_vec & ~valid_vec) == '0);
endmodule

bind split_mac_tracker split_mac_tracker_chk #(.DEPTH(DEPTH), .MAC_W(MAC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dat_ready      (dat_ready),
    .valid_vec      (valid_vec),
    .verified_vec   (verified_vec),
    .mac_valid      (mac_valid),
    .mac_expect     (mac_expect),
    .mac_recv       (mac_recv),
    .hit_found      (hit_found),
    .hit_idx        (hit_idx),
    .rel_valid      (rel_valid),
    .rel_tag        (rel_tag),
    .fault_mismatch (fault_mismatch),
    .fault_orphan   (fault_orphan)
);

// File: tb/split_mac_tracker_test.sv
`timescale 1ns/1ps
module split_mac_tracker_test;
    localparam int DEPTH = 8;
    localparam int ID_W  = 8;
    localparam int SEQ_W = 16;
    localparam int MAC_W = 32;
    localparam int IDX_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             dat_valid = 1'b0;
    logic [ID_W-1:0]  dat_id = '0;
    logic [SEQ_W-1:0] dat_seq = '0;
    logic             dat_ready;
    logic [IDX_W-1:0] dat_tag;
    logic             mac_valid = 1'b0;
    logic [ID_W-1:0]  mac_id = '0;
    logic [MAC_W-1:0] mac_expect = '0;
    logic [MAC_W-1:0] mac_recv = '0;
    logic [IDX_W-1:0] qry_tag = '0;
    logic             qry_valid;
    logic             qry_verified;
    logic [ID_W-1:0]  qry_id;
    logic [SEQ_W-1:0] qry_seq;
    logic             rel_valid = 1'b0;
    logic [IDX_W-1:0] rel_tag = '0;
    logic             fault_mismatch;
    logic             fault_orphan;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    split_mac_tracker #(.DEPTH(DEPTH), .ID_W(ID_W), .SEQ_W(SEQ_W), .MAC_W(MAC_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .dat_valid(dat_valid), .dat_id(dat_id), .dat_seq(dat_seq),
        .dat_ready(dat_ready), .dat_tag(dat_tag),
        .mac_valid(mac_valid), .mac_id(mac_id), .mac_expect(mac_expect), .mac_recv(mac_recv),
        .qry_tag(qry_tag), .qry_valid(qry_valid), .qry_verified(qry_verified),
        .qry_id(qry_id), .qry_seq(qry_seq),
        .rel_valid(rel_valid), .rel_tag(rel_tag),
        .fault_mismatch(fault_mismatch), .fault_orphan(fault_orphan)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        dat_valid = 0; mac_valid = 0; rel_valid = 0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic query(input int tag, output logic v, output logic ver,
                         output logic [ID_W-1:0] id, output logic [SEQ_W-1:0] sq);
        qry_tag = IDX_W'(tag);
        #0.5;
        v = qry_valid; ver = qry_verified; id = qry_id; sq = qry_seq;
    endtask

    task automatic push(input int id, input int sq);
        dat_valid = 1'b1; dat_id = ID_W'(id); dat_seq = SEQ_W'(sq);
        tick();
        dat_valid = 1'b0;
    endtask

    task automatic code(input int id, input int e, input int r);
        mac_valid = 1'b1; mac_id = ID_W'(id); mac_expect = MAC_W'(e); mac_recv = MAC_W'(r);
        tick();
        mac_valid = 1'b0;
    endtask

    task automatic release_tag(input int tag);
        rel_valid = 1'b1; rel_tag = IDX_W'(tag);
        tick();
        rel_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic v, ver; logic [ID_W-1:0] id; logic [SEQ_W-1:0] sq;
        do_reset();
        check("R1", "ready", dat_ready, 1);
        check("R1", "tag", dat_tag, 0);
        check("R1", "mismatch", fault_mismatch, 0);
        check("R1", "orphan", fault_orphan, 0);
        for (int i = 0; i < DEPTH; i++) begin
            query(i, v, ver, id, sq);
            check("R1", "valid", v, 0);
            check("R1", "verified", ver, 0);
        end
    endtask

    task automatic t_interleave();
        logic v, ver; logic [ID_W-1:0] id; logic [SEQ_W-1:0] sq;
        do_reset();
        #0.5 check("R2", "first tag", dat_tag, 0);
        push(5, 100);
        #0.5 check("R2", "second tag", dat_tag, 1);
        push(6, 101);
        query(0, v, ver, id, sq);
        check("R2", "t0 valid", v, 1); check("R2", "t0 ver", ver, 0);
        check("R2", "t0 id", id, 5);   check("R2", "t0 seq", sq, 100);
        // code for id 5 arrives together with data for id 7 (tag 2)
        dat_valid = 1'b1; dat_id = 7; dat_seq = 102;
        code(5, 32'hA5A5, 32'hA5A5);
        dat_valid = 1'b0;
        query(0, v, ver, id, sq);
        check("R4", "t0 verified", ver, 1);
        query(1, v, ver, id, sq);
        check("R4", "t1 untouched", ver, 0);
        query(2, v, ver, id, sq);
        check("R2", "t2 id", id, 7); check("R4", "t2 unverified", ver, 0);
        check("R4", "no fault", fault_mismatch | fault_orphan, 0);
        // bad code for id 6
        code(6, 32'h1111, 32'h1112);
        check("R5", "mismatch pulse", fault_mismatch, 1);
        check("R7", "orphan low", fault_orphan, 0);
        query(1, v, ver, id, sq);
        check("R5", "t1 still unverified", ver, 0);
        tick();
        check("R5", "pulse one cycle", fault_mismatch, 0);
        // orphan: unknown id, then an id whose slot is already verified
        code(77, 1, 1);
        check("R6", "orphan unknown", fault_orphan, 1);
        check("R7", "mismatch low", fault_mismatch, 0);
        code(5, 2, 2);
        check("R6", "orphan verified id", fault_orphan, 1);
        query(0, v, ver, id, sq);
        check("R6", "t0 unchanged", v & ver, 1);
        tick();
        check("R6", "orphan one cycle", fault_orphan, 0);
    endtask

    task automatic t_release();
        logic v, ver; logic [ID_W-1:0] id; logic [SEQ_W-1:0] sq;
        do_reset();
        push(1, 10); push(2, 20);
        code(1, 9, 9);
        release_tag(1);
        query(1, v, ver, id, sq);
        check("R9", "unverified kept", v, 1);
        check("R9", "unverified id", id, 2);
        release_tag(0);
        query(0, v, ver, id, sq);
        check("R9", "verified freed", v, 0);
        check("R10", "freed not verified", ver, 0);
        #0.5 check("R9", "freed slot reused", dat_tag, 0);
    endtask

    task automatic t_full();
        logic v, ver; logic [ID_W-1:0] id; logic [SEQ_W-1:0] sq;
        do_reset();
        for (int i = 0; i < DEPTH; i++) push(20 + i, 200 + i);
        #0.5 check("R3", "ready low when full", dat_ready, 0);
        push(99, 999);
        for (int i = 0; i < DEPTH; i++) begin
            query(i, v, ver, id, sq);
            check("R3", "slot intact", sq, 200 + i);
        end
        code(23, 4, 4);
        release_tag(3);
        #0.5 check("R3", "ready after release", dat_ready, 1);
        check("R2", "tag after release", dat_tag, 3);
    endtask

    task automatic t_duplicate();
        logic v, ver; logic [ID_W-1:0] id; logic [SEQ_W-1:0] sq;
        do_reset();
        push(9, 1); push(9, 2);
        code(9, 3, 3);
        query(0, v, ver, id, sq);
        check("R8", "lowest verified first", ver, 1);
        query(1, v, ver, id, sq);
        check("R8", "second pending", ver, 0);
        code(9, 3, 3);
        query(1, v, ver, id, sq);
        check("R8", "second verified", ver, 1);
        check("R8", "no fault", fault_orphan | fault_mismatch, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_interleave();
        t_release();
        t_full();
        t_duplicate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule